// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a frame DMA. Software builds a table of 8-byte descriptors in memory. Each descriptor holds a control word (word 0) and a buffer pointer word (word 1). Software gives the block the table location and the starting entry, then sets a transmit-enable bit. The walker then fetches descriptors one at a time and works on each descriptor that is marked as owned by hardware. For such a descriptor it issues a frame request downstream that carries the buffer address and a set of per-frame option flags.

When the downstream frame generator reports that the frame is finished, the walker writes word 0 back to memory. In that write the ownership bit is cleared and the underrun status is recorded. The walker can also raise an interrupt pulse. It then moves to the next entry.

The table is 1 KiB long and must start on a 1 KiB boundary. It wraps by itself after its last entry, and any descriptor can force an early wrap. The walker stops when it meets a descriptor that software has not handed over. When it stops, it drops transmit-enable and leaves the pointer on that entry, so software can refill the entry and restart.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After reset, both registers read as zero, `irq` is low and `mem_req` is low.
- R2: Register select 1 is the pointer register. Bits 31:10 hold the table base and bits 9:3 hold the entry index. Bits 2:0 read as zero whatever was written. Every memory access of the walker falls inside the 1 KiB table. Word 0 of an entry is at table base + index*8 and word 1 is at that address + 4. `mem_req`, `mem_we` and `mem_addr` are held steady until `mem_ack`.
- R3: After an entry has been written back, the index goes up by one. After entry 127 it returns to 0.
- R4: When bit 1 of word 0 is set, the index returns to 0 after that entry, whatever the index was.
- R5: When a fetched word 0 has bit 0 (ownership) clear, the walker issues no frame request and clears transmit-enable. The index stays on that entry.
- R6: A frame request carries `frm_addr` = word 1 with bits 1:0 forced to zero. It also carries `frm_flags`, taken from word 0 as follows: [0] = bit 3, [1] = bit 5, [2] = bit 6, [3] = bit 8, [4] = bit 9, [5] = bit 14. Address and flags stay stable while `frm_valid` waits for `frm_ready`.
- R7: After `frm_done`, word 0 is written back unchanged except for two bits. Bit 0 is cleared. Bit 15 takes the value of `frm_underrun` sampled with `frm_done`.
- R8: Once the write-back has been acknowledged, `irq` pulses for exactly one cycle if word 0 bit 2 is set and the control register's interrupt-enable bit is set. This happens whether or not an underrun was reported. Otherwise `irq` stays low.
- R9: Register select 0 is the control register. Bit 0 is transmit-enable and bit 1 is interrupt-enable. Writing 1 to bit 0 sets transmit-enable. Writing 0 to bit 0 has no effect, because only the walker clears it. Bit 1 takes the written value. No memory access starts while transmit-enable is clear.
- R10: A write to the pointer register is ignored while transmit-enable is set or while the walker is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control, 1 = pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle acknowledge of the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| frm_valid | output | 1 | Frame request pending |
| frm_ready | input | 1 | Downstream accepts the request |
| frm_addr | output | 32 | Word-aligned buffer address |
| frm_flags | output | 6 | Per-frame option flags |
| frm_done | input | 1 | One-cycle pulse: the current frame is finished |
| frm_underrun | input | 1 | Underrun status, valid with `frm_done` |
| irq | output | 1 | Frame-complete interrupt pulse |

## Verification
The bench starts the walker at index 126 so that it must pass from entry 127 to entry 0. A walker that carried the index into the base field would fetch outside the table. The bench also places a wrap bit in the middle of the table; a walker that ignored it would read entry 6 when it should read entry 0. A run that starts on a descriptor not owned by hardware must leave the pointer unchanged and produce no frame; a walker that moved past such an entry would skip work that software queues later. During a run the bench writes both registers, checking that a pointer write lands nowhere and that writing 0 to transmit-enable does not stop the run. Random tables with random reserved bits and random underrun reports catch write-back that disturbs bits other than 0 and 15, and interrupts that depend on the underrun outcome.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_SEND,
        ST_WAIT,
        ST_WB
    } walk_st_e;

    // Control word bit positions decoded by the walker
    localparam int W0_OWN  = 0;
    localparam int W0_WRAP = 1;
    localparam int W0_IRQ  = 2;
    localparam int W0_URUN = 15;

    // Forwarded option flags: frm_flags[i] = word0[FLAG_POS[i]]
    localparam int FLAG_W = 6;
    localparam int FLAG_POS [FLAG_W] = '{3, 5, 6, 8, 9, 14};

    // Register selects and control bits
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_PTR  = 1'b1;
    localparam int   CTRL_RUN = 0;
    localparam int   CTRL_IEN = 1;

    function automatic logic [FLAG_W-1:0] pick_flags(input logic [31:0] w0);
        logic [FLAG_W-1:0] f;
        for (int i = 0; i < FLAG_W; i++) begin
            f[i] = w0[FLAG_POS[i]];
        end
        return f;
    endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
#(
    parameter int TABLE_BYTES = 1024,
    parameter int DESC_BYTES  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        sel,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        advance,
    input  logic        adv_wrap,
    input  logic        clr_run,
    input  logic        busy,
    output logic        run,
    output logic        irq_en,
    output logic [31:0] desc_addr
);
    localparam int OFS_LSB  = $clog2(DESC_BYTES);
    localparam int BASE_LSB = $clog2(TABLE_BYTES);
    localparam int IDX_W    = BASE_LSB - OFS_LSB;
    localparam int BASE_W   = 32 - BASE_LSB;

    typedef struct packed {
        logic              run;
        logic              ien;
        logic [BASE_W-1:0] base;
        logic [IDX_W-1:0]  idx;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  sw_start;
    logic  unused_wbits;

    assign unused_wbits = ^wdata[OFS_LSB-1:0];
    assign sw_start     = wr_en && (sel == SEL_CTRL) && wdata[CTRL_RUN];

    always_comb begin
        regs_d = regs_q;
        if (advance) begin
            regs_d.idx = adv_wrap ? '0 : regs_q.idx + 1'b1;
        end
        if (clr_run) begin
            regs_d.run = 1'b0;
        end
        if (wr_en) begin
            if (sel == SEL_CTRL) begin
                if (wdata[CTRL_RUN]) begin
                    regs_d.run = 1'b1;
                end
                regs_d.ien = wdata[CTRL_IEN];
            end else if (!regs_q.run && !busy) begin
                regs_d.base = wdata[31:BASE_LSB];
                regs_d.idx  = wdata[BASE_LSB-1:OFS_LSB];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign desc_addr = {regs_q.base, regs_q.idx, {OFS_LSB{1'b0}}};
    assign rdata     = (sel == SEL_PTR) ? desc_addr
                                        : {{30{1'b0}}, regs_q.ien, regs_q.run};
    assign run       = regs_q.run;
    assign irq_en    = regs_q.ien;

    AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.run || busy) && !advance |=> $stable(desc_addr)); // R10
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !adv_wrap |=> regs_q.idx == IDX_W'($past(regs_q.idx) + 1'b1)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        advance && adv_wrap |=> regs_q.idx == '0); // R4
    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_run && !sw_start |=> !regs_q.run); // R5

endmodule

// File: rtl/txd_walker.sv
module txd_walker
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              irq_en,
    input  logic [31:0]       desc_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [31:0]       frm_addr,
    output logic [FLAG_W-1:0] frm_flags,
    input  logic              frm_done,
    input  logic              frm_underrun,
    output logic              irq,
    output logic              advance,
    output logic              adv_wrap,
    output logic              clr_run,
    output logic              busy
);
    typedef struct packed {
        walk_st_e    st;
        logic [31:0] w0;
        logic [29:0] buf_w;
        logic        urun;
        logic        irq;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  wb_done;

    assign wb_done = (walk_q.st == ST_WB) && mem_ack;

    always_comb begin
        walk_d     = walk_q;
        walk_d.irq = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (run) walk_d.st = ST_RD0;
            end
            ST_RD0: begin
                if (mem_ack) begin
                    walk_d.w0 = mem_rdata;
                    walk_d.st = mem_rdata[W0_OWN] ? ST_RD1 : ST_IDLE;
                end
            end
            ST_RD1: begin
                if (mem_ack) begin
                    walk_d.buf_w = mem_rdata[31:2];
                    walk_d.st    = ST_SEND;
                end
            end
            ST_SEND: begin
                if (frm_ready) walk_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (frm_done) begin
                    walk_d.urun = frm_underrun;
                    walk_d.st   = ST_WB;
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    walk_d.irq = walk_q.w0[W0_IRQ] && irq_en;
                    walk_d.st  = ST_IDLE;
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        mem_wdata         = walk_q.w0;
        mem_wdata[W0_OWN] = 1'b0;
        mem_wdata[W0_URUN] = walk_q.urun;
    end

    assign mem_req   = (walk_q.st == ST_RD0) || (walk_q.st == ST_RD1) || (walk_q.st == ST_WB);
    assign mem_we    = (walk_q.st == ST_WB);
    assign mem_addr  = (walk_q.st == ST_RD1) ? (desc_addr | 32'h4) : desc_addr;
    assign frm_valid = (walk_q.st == ST_SEND);
    assign frm_addr  = {walk_q.buf_w, 2'b00};
    assign frm_flags = pick_flags(walk_q.w0);
    assign irq       = walk_q.irq;
    assign advance   = wb_done;
    assign adv_wrap  = walk_q.w0[W0_WRAP];
    assign clr_run   = (walk_q.st == ST_RD0) && mem_ack && !mem_rdata[W0_OWN];
    assign busy      = (walk_q.st != ST_IDLE);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_addr) && $stable(frm_flags)); // R6
    AST_NO_FETCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !busy |=> !mem_req); // R9

endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
    import txd_pkg::*;
#(
    parameter int TABLE_BYTES = 1024,
    parameter int DESC_BYTES  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        frm_valid,
    input  logic        frm_ready,
    output logic [31:0] frm_addr,
    output logic [5:0]  frm_flags,
    input  logic        frm_done,
    input  logic        frm_underrun,
    output logic        irq
);
    logic        run, irq_en, advance, adv_wrap, clr_run, busy;
    logic [31:0] desc_addr;

    txd_regs #(
        .TABLE_BYTES(TABLE_BYTES),
        .DESC_BYTES (DESC_BYTES)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .advance  (advance),
        .adv_wrap (adv_wrap),
        .clr_run  (clr_run),
        .busy     (busy),
        .run      (run),
        .irq_en   (irq_en),
        .desc_addr(desc_addr)
    );

    txd_walker u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .irq_en      (irq_en),
        .desc_addr   (desc_addr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .frm_valid   (frm_valid),
        .frm_ready   (frm_ready),
        .frm_addr    (frm_addr),
        .frm_flags   (frm_flags),
        .frm_done    (frm_done),
        .frm_underrun(frm_underrun),
        .irq         (irq),
        .advance     (advance),
        .adv_wrap    (adv_wrap),
        .clr_run     (clr_run),
        .busy        (busy)
    );

endmodule

// File: tb/txdesc_ring_engine_tb_top.sv
module txdesc_ring_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        frm_valid, frm_ready = 1'b0, frm_done = 1'b0, frm_underrun = 1'b0;
    logic [31:0] frm_addr;
    logic [5:0]  frm_flags;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_addr(frm_addr), .frm_flags(frm_flags),
        .frm_done(frm_done), .frm_underrun(frm_underrun), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];
    logic [31:0] cur_base = '0;
    int oob_cnt = 0, irq_cnt = 0, req_cycles = 0;
    logic [31:0] cap_addr [512];
    logic [5:0]  cap_flags [512];
    logic        cap_ue [512];
    int cap_n = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_flags(input logic [31:0] w);
        return {w[14], w[9], w[8], w[6], w[5], w[3]};
    endfunction

    // Memory responder: one-cycle acknowledge, gap cycle after each
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                mem_ack = 1'b1;
                if (mem_addr[31:10] != cur_base[31:10]) begin
                    oob_cnt++;
                    mem_rdata = '0;
                end else if (mem_we) begin
                    mem[mem_addr[9:2]] = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                end
            end
        end
    end

    // Downstream frame model
    initial begin
        int phase = 0, dly = 0;
        forever begin
            @(negedge clk);
            case (phase)
                0: if (frm_valid) begin
                    if (cap_n < 512) begin
                        cap_addr[cap_n]  = frm_addr;
                        cap_flags[cap_n] = frm_flags;
                        cap_n++;
                    end
                    frm_ready = 1'b1;
                    phase = 1;
                end
                1: begin
                    frm_ready = 1'b0;
                    dly = 1 + int'($urandom % 4);
                    phase = 2;
                end
                2: begin
                    dly--;
                    if (dly == 0) begin
                        frm_done = 1'b1;
                        frm_underrun = ($urandom % 3) == 0;
                        if (cap_n > 0) cap_ue[cap_n-1] = frm_underrun;
                        phase = 3;
                    end
                end
                default: begin
                    frm_done = 1'b0;
                    frm_underrun = 1'b0;
                    phase = 0;
                end
            endcase
        end
    end

    // Monitors
    initial begin
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
            if (mem_req) req_cycles++;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: run did not end, actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    task automatic reg_write(input logic s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic clear_table();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic run_case(input logic [31:0] base, input int start, input bit ien,
                            input bit poke, input string ptag);
        logic [31:0] v, w, orig;
        int idx, k, ien_cnt, irq0, oob0, lim, mm;
        logic ue;
        base = base & 32'hFFFF_FC00;
        cur_base = base;
        reg_write(1'b1, base | (32'(start) << 3) | ($urandom & 32'h7));
        reg_write(1'b0, {30'b0, ien, 1'b0});
        reg_read(1'b1, v);
        chk(v == (base | (32'(start) << 3)), "R2", "pointer readback", v, base | (32'(start) << 3));
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        cap_n = 0;
        irq0 = irq_cnt;
        oob0 = oob_cnt;
        reg_write(1'b0, {30'b0, ien, 1'b1});
        if (poke) begin
            repeat (8) @(negedge clk);
            reg_write(1'b1, ~base);
            reg_write(1'b0, {30'b0, ien, 1'b0});
            reg_read(1'b0, v);
            chk(v[0] == 1'b1, "R9", "transmit-enable after writing 0", {31'b0, v[0]}, 32'd1);
            chk(v[1] == ien, "R9", "interrupt-enable after write", {31'b0, v[1]}, {31'b0, ien});
        end
        lim = 0;
        do begin
            reg_read(1'b0, v);
            lim++;
        end while (v[0] && lim < 40000);
        repeat (4) @(negedge clk);
        // Model walk
        idx = start; k = 0; ien_cnt = 0;
        while (k < 400) begin
            orig = exp_mem[idx*2];
            if (!orig[0]) break;
            if (k < cap_n) begin
                chk(cap_addr[k] == {exp_mem[idx*2+1][31:2], 2'b00}, "R6", "frame buffer address",
                    cap_addr[k], {exp_mem[idx*2+1][31:2], 2'b00});
                chk(cap_flags[k] == exp_flags(orig), "R6", "frame flags",
                    {26'b0, cap_flags[k]}, {26'b0, exp_flags(orig)});
            end
            ue = (k < cap_n) ? cap_ue[k] : 1'b0;
            w = orig; w[0] = 1'b0; w[15] = ue;
            exp_mem[idx*2] = w;
            if (orig[2] && ien) ien_cnt++;
            idx = orig[1] ? 0 : (idx + 1) % 128;
            k++;
        end
        chk(cap_n == k, "R5", "frame count", 32'(cap_n), 32'(k));
        mm = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mm++;
        chk(mm == 0, "R7", "write-back image mismatches", 32'(mm), 32'd0);
        chk(irq_cnt - irq0 == ien_cnt, "R8", "interrupt pulses", 32'(irq_cnt - irq0), 32'(ien_cnt));
        reg_read(1'b1, v);
        chk(v == (base | (32'(idx) << 3)), ptag, "final pointer", v, base | (32'(idx) << 3));
        chk(oob_cnt == oob0, "R2", "accesses outside table", 32'(oob_cnt - oob0), 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int r0;
        void'($urandom(32'h1D5E_ED01));
        clear_table();
        repeat (5) @(negedge clk);
        // R1: reset state
        reg_read(1'b0, v);
        chk(v == 0, "R1", "control after reset", v, 0);
        reg_read(1'b1, v);
        chk(v == 0, "R1", "pointer after reset", v, 0);
        chk(irq == 0 && mem_req == 0, "R1", "irq/mem_req after reset", {30'b0, irq, mem_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        reg_read(1'b0, v);
        chk(v == 0, "R1", "control after release", v, 0);

        // R9: nothing fetched without transmit-enable
        mem[0] = 32'h1;
        r0 = req_cycles;
        reg_write(1'b0, 32'h2);
        repeat (20) @(negedge clk);
        chk(req_cycles == r0, "R9", "fetch cycles while disabled", 32'(req_cycles - r0), 0);

        // Directed: four frames from entry 0, mid-run register writes (R10)
        clear_table();
        mem[0] = 32'h0000_4005; mem[1] = 32'h1000_0003;
        mem[2] = 32'hABCD_0369; mem[3] = 32'h1000_0101;
        mem[4] = 32'h0000_0205; mem[5] = 32'h2000_0200;
        mem[6] = 32'h0000_0109; mem[7] = 32'h2000_0302;
        run_case(32'h0001_2C00, 0, 1'b1, 1'b1, "R10");

        // Directed: end-of-table wrap (R3), interrupts disabled
        clear_table();
        mem[252] = 32'h0000_0065; mem[253] = 32'h3000_0000;
        mem[254] = 32'h0000_4005; mem[255] = 32'h3000_0010;
        mem[0]   = 32'h0000_0005; mem[1]   = 32'h3000_0020;
        run_case(32'h8000_0400, 126, 1'b0, 1'b0, "R3");

        // Directed: early wrap bit (R4)
        clear_table();
        mem[10] = 32'h0000_0007; mem[11] = 32'h4000_0040;
        mem[12] = 32'h0000_0001; mem[13] = 32'h4000_0050;
        run_case(32'h0000_0000, 5, 1'b1, 1'b0, "R4");

        // Directed: first entry not owned (R5)
        clear_table();
        mem[40] = 32'hFFFF_FFFE; mem[41] = 32'h5000_0000;
        run_case(32'h7777_7C00, 20, 1'b1, 1'b0, "R5");

        // Random tables
        for (int rnd = 0; rnd < 6; rnd++) begin
            for (int e = 0; e < 128; e++) begin
                logic [31:0] w0;
                w0 = $urandom;
                w0[0] = ($urandom % 8) != 0;
                w0[1] = ($urandom % 16) == 0;
                mem[e*2] = w0;
                mem[e*2+1] = $urandom;
            end
            run_case($urandom, int'($urandom % 128), 1'($urandom), 1'b0, "R3");
        end

        summary();
        $finish;
    end

endmodule